// File: doc/BRIEF.md
# Masked Bit-Pattern Interrupt Condition Detector

This block monitors an 8-bit input port and raises an interrupt request when a programmable condition on the port lines becomes true. Software writes a mask register and a 2-bit control field. The mask selects which lines take part. The control field chooses between two ways of combining those lines: any one active or all of them active. It also chooses whether a line counts as active when it is high or when it is low.

The port inputs are synchronised to the block clock before the condition is evaluated. A request is raised only when the combined result changes from false to true. A result that stays true raises nothing further.

While the processor's opcode-fetch (M1) signal is high, no new request may start. A rise that occurs just before or during that phase is held. It is then posted on the first clock edge after M1 falls.

The request stays high until the downstream daisy-chain controller acknowledges it. Vector delivery and chain priority are handled in that controller.

Top module: `bitpat_irq_detect`

## Requirements
- R1: After reset `irq_o` is low and the mask register holds all ones. With that mask, no port activity raises a request until the mask is rewritten.
- R2: With control bits `wdata_i[1:0]` written as `10` (bit 0 = 0 selects any-line combining, bit 1 = 1 selects high-active sensing), the condition is true when at least one unmasked line is high.
- R3: With control bit 0 = 1, the condition is true only when every unmasked line is active under the selected sensing.
- R4: With control bit 1 = 0, a line counts as active when it is low. This holds for both combining choices.
- R5: A mask bit of 1 excludes the matching port line. When all 8 mask bits are 1, the condition is false.
- R6: A request is raised only on a false-to-true change of the condition. A condition that stays true raises no further request. In any-line mode, a second unmasked line going active while the first is still active raises nothing.
- R7: No request starts on a clock edge where `m1_i` is high. A rise seen just before or during M1 is posted on the first edge with `m1_i` low.
- R8: A rise that occurs while `irq_en_i` is low is discarded. It raises no request, even after the enable returns.
- R9: `ack_i` clears `irq_o` on the next edge unless a new rise posts a request on that same edge. Port changes reach the condition after a 2-flop synchroniser, so `irq_o` rises on the third edge after a port change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| port_i | input | 8 | Port data lines (asynchronous) |
| wdata_i | input | 8 | Register write data |
| mask_we_i | input | 1 | Write strobe for the mask register |
| ctrl_we_i | input | 1 | Write strobe for the control field (`wdata_i[1:0]`) |
| irq_en_i | input | 1 | Interrupt enable for this port |
| m1_i | input | 1 | Opcode-fetch phase indicator; blocks new requests |
| ack_i | input | 1 | Acknowledge from the daisy-chain controller |
| irq_o | output | 1 | Pending interrupt request |

## Verification
The assertions assume that `ack_i` is a single-cycle pulse issued only after a request has been observed. They also assume that `m1_i` and `irq_en_i` are synchronous to `clk_i`. The bench drives every input on the falling edge. It holds each port pattern for several cycles, so that each step of the sweep produces at most one condition edge. It pulses acknowledge only after the request output has been sampled, which keeps the stimulus inside those assumptions.

// File: rtl/bpd_pkg.sv
package bpd_pkg;
  typedef enum logic {COMB_ANY = 1'b0, COMB_ALL = 1'b1} comb_e;
  typedef enum logic {SENSE_LOW = 1'b0, SENSE_HIGH = 1'b1} sense_e;

  // bit 1 sense, bit 0 combine
  typedef struct packed {
    sense_e sense;
    comb_e  comb;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{sense: SENSE_LOW, comb: COMB_ANY};
endpackage

// File: rtl/bpd_sync.sv
module bpd_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/bpd_eval.sv
module bpd_eval
  import bpd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  input  logic [W-1:0] mask_i,
  input  ctrl_t        ctrl_i,
  output logic         hit_o
);
  logic [W-1:0] lvl;
  logic         any_act, all_act, none_used;

  always_comb begin
    lvl       = (ctrl_i.sense == SENSE_HIGH) ? data_i : ~data_i;
    any_act   = |(lvl & ~mask_i);
    all_act   = &(lvl | mask_i);
    none_used = &mask_i;
    hit_o     = !none_used && ((ctrl_i.comb == COMB_ALL) ? all_act : any_act);
  end

  // R5
  always_comb begin
    if (mask_i == '1) all_masked_chk: assert (!hit_o);
  end
endmodule

// File: rtl/bpd_trigger.sv
module bpd_trigger (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic irq_en_i,
  input  logic m1_i,
  input  logic ack_i,
  output logic irq_o
);
  logic prev_q, defer_q, irq_q;
  logic rise, want;

  assign rise = hit_i & ~prev_q;
  assign want = irq_en_i & (rise | defer_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      defer_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      prev_q  <= hit_i;
      defer_q <= want & m1_i;                         // held until M1 ends
      irq_q   <= (want & ~m1_i) | (irq_q & ~ack_i);   // new post beats ack
    end
  end

  assign irq_o = irq_q;

  // R7
  no_post_in_m1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m1_i && !irq_o) |=> !irq_o);
  // R8
  no_post_disabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_en_i && !irq_o) |=> !irq_o);
  // R9
  ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && m1_i) |=> !irq_o);
  // R6
  steady_true_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_i && prev_q && !defer_q && !irq_o) |=> !irq_o);
endmodule

// File: rtl/bitpat_irq_detect.sv
module bitpat_irq_detect
  import bpd_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] port_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             mask_we_i,
  input  logic             ctrl_we_i,
  input  logic             irq_en_i,
  input  logic             m1_i,
  input  logic             ack_i,
  output logic             irq_o
);
  localparam int CW = $bits(ctrl_t);

  logic [WIDTH-1:0] mask_q, port_s;
  ctrl_t            ctrl_q;
  logic             hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
      ctrl_q <= CTRL_RST;
    end else begin
      if (mask_we_i) mask_q <= wdata_i;
      if (ctrl_we_i) ctrl_q <= ctrl_t'(wdata_i[CW-1:0]);
    end
  end

  bpd_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (port_s)
  );

  bpd_eval #(.W(WIDTH)) u_eval (
    .data_i(port_s),
    .mask_i(mask_q),
    .ctrl_i(ctrl_q),
    .hit_o (hit)
  );

  bpd_trigger u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .irq_en_i(irq_en_i),
    .m1_i    (m1_i),
    .ack_i   (ack_i),
    .irq_o   (irq_o)
  );

  // R1
  rst_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !irq_o);
endmodule

// File: tb/bitpat_irq_detect_bench.sv
module bitpat_irq_detect_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] port_i = '0, wdata_i = '0;
  logic       mask_we_i = 0, ctrl_we_i = 0, irq_en_i = 1, m1_i = 0, ack_i = 0;
  logic       irq_o;
  int         total = 0, bad = 0;

  always #10 clk = ~clk;  // 50 MHz

  bitpat_irq_detect u_bitpat_irq_detect (
    .clk_i(clk), .rst_ni(rst_ni), .port_i(port_i), .wdata_i(wdata_i),
    .mask_we_i(mask_we_i), .ctrl_we_i(ctrl_we_i), .irq_en_i(irq_en_i),
    .m1_i(m1_i), .ack_i(ack_i), .irq_o(irq_o)
  );

  function automatic bit model(input logic [7:0] p, input logic [7:0] m, input logic [1:0] c);
    int n_um = 0, n_act = 0;
    for (int i = 0; i < 8; i++)
      if (!m[i]) begin
        n_um++;
        if (p[i] == c[1]) n_act++;
      end
    if (n_um == 0) return 1'b0;
    return c[0] ? (n_act == n_um) : (n_act > 0);
  endfunction

  task automatic check(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: irq_o=%b expected=%b (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic wr_mask(input logic [7:0] m);
    wdata_i = m; mask_we_i = 1; @(negedge clk); mask_we_i = 0;
  endtask

  task automatic wr_ctrl(input logic [1:0] c);
    wdata_i = {6'd0, c}; ctrl_we_i = 1; @(negedge clk); ctrl_we_i = 0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic ack_pulse();
    ack_i = 1; @(negedge clk); ack_i = 0; @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: irq_o=%b expected=finish", irq_o);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] masks [4];
    logic       prev, cur, e;
    string      tag;
    masks[0] = 8'h00; masks[1] = 8'h0F; masks[2] = 8'hA5; masks[3] = 8'hFF;

    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R1: reset state and all-masked default
    check(irq_o, 1'b0, "R1");
    for (int p = 0; p < 256; p += 17) begin
      port_i = p[7:0]; settle();
      check(irq_o, 1'b0, "R1");
    end
    port_i = 8'h00; settle();

    // Sweep: every pattern for each control mode and several masks (R2..R5, R9)
    for (int c = 0; c < 4; c++) begin
      for (int mi = 0; mi < 4; mi++) begin
        wr_mask(masks[mi]); wr_ctrl(c[1:0]); settle(); ack_pulse();
        prev = model(port_i, masks[mi], c[1:0]);
        if (masks[mi] == 8'hFF) tag = "R5";
        else if (c[0]) tag = "R3";
        else if (c[1]) tag = "R2";
        else tag = "R4";
        for (int p = 0; p < 256; p++) begin
          port_i = p[7:0]; settle();
          cur = model(p[7:0], masks[mi], c[1:0]);
          e = cur & ~prev;
          check(irq_o, e, tag);
          ack_pulse();
          if (e) check(irq_o, 1'b0, "R9");
          prev = cur;
        end
      end
    end

    // R9: latency of three edges from port change
    wr_ctrl(2'b10); wr_mask(8'hFE); port_i = 8'h00; settle(); ack_pulse();
    port_i = 8'h01;
    repeat (2) @(negedge clk);
    check(irq_o, 1'b0, "R9");
    @(negedge clk);
    check(irq_o, 1'b1, "R9");
    ack_pulse();

    // R6: any-line mode, second line joins while first active
    port_i = 8'h00; wr_mask(8'hFC); settle(); ack_pulse();
    port_i = 8'h01; settle();
    check(irq_o, 1'b1, "R6");
    ack_pulse();
    port_i = 8'h03; settle();
    check(irq_o, 1'b0, "R6");
    repeat (10) @(negedge clk);
    check(irq_o, 1'b0, "R6");

    // R7: rise during M1 is held until M1 ends
    port_i = 8'h00; wr_mask(8'hFE); settle(); ack_pulse();
    m1_i = 1; port_i = 8'h01; settle(); repeat (4) @(negedge clk);
    check(irq_o, 1'b0, "R7");
    m1_i = 0; @(negedge clk);
    check(irq_o, 1'b1, "R7");
    ack_pulse();
    // R7: rise just before M1
    port_i = 8'h00; settle();
    port_i = 8'h01; repeat (2) @(negedge clk); m1_i = 1;
    repeat (3) @(negedge clk);
    check(irq_o, 1'b0, "R7");
    m1_i = 0; @(negedge clk);
    check(irq_o, 1'b1, "R7");
    ack_pulse();

    // R8: rise while disabled is dropped
    port_i = 8'h00; settle();
    irq_en_i = 0; port_i = 8'h01; settle();
    check(irq_o, 1'b0, "R8");
    irq_en_i = 1; settle();
    check(irq_o, 1'b0, "R8");
    port_i = 8'h00; settle(); port_i = 8'h01; settle();
    check(irq_o, 1'b1, "R8");
    ack_pulse();
    check(irq_o, 1'b0, "R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule